// File: doc/BRIEF.md
# Step Attenuator Control Front End

This block turns control inputs into the 6-bit code that sets a binary-weighted step attenuator. It has two ways to set the code. The first is a serial path: a data line, a shift clock and a latch-enable line load a 6-bit shift register. The register feeds the output through a latch that is transparent while latch-enable is high. The second is a direct parallel path, where six control lines drive the code with no strobe. A mode input chooses which path owns the output.

When reset releases, the output already holds a known code. Two selection inputs pick that code: zero, the maximum, a mid-scale value, or whatever sits on the parallel lines. The output keeps this code until the first write through the active path.

The serial inputs are sampled by the system clock, which is far faster than the serial clock. Shifting happens on the sampled rising edge of the serial clock. The output code is a register.

Top module: `step_atten_ctrl`

## Requirements
- R1: While `rst` is high, the output loads the power-up code chosen by `pup_sel`. 00 gives 0, 01 gives 63 (all ones), 10 gives 32 (only bit 5 set), and 11 gives the value on `par_code`.
- R2: Each rising edge of `ser_clk` shifts `ser_data` into bit 0 of the shift register, so the first bit of a word ends in bit 5 (MSB first). Only the last six bits received are kept. Shifting happens at any level of `ser_le` and in either mode.
- R3: In serial mode (`par_mode` = 0) with `ser_le` low, `att_code` does not change while bits are shifted in.
- R4: In serial mode with `ser_le` high, `att_code` follows the shift register within three system clocks of any change, including changes made while `ser_le` stays high.
- R5: In parallel mode (`par_mode` = 1), a change on `par_code` appears on `att_code` on the next system clock edge.
- R6: After reset, the power-up code stays on `att_code` until the first `ser_le` high in serial mode, or the first change of `par_code` in parallel mode.
- R7: Code bit k carries a weight of 0.5·2^k dB. Bit 5 is 16 dB and bit 0 is 0.5 dB, which gives 64 settings from 0 to 31.5 dB.
- R8: In parallel mode, `ser_le` has no effect on `att_code`.
- R9: In serial mode, changes on `par_code` have no effect on `att_code`.
- R10: Reset clears the shift register, so a latch-enable pulse with no bits shifted after reset outputs 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| par_mode | input | 1 | 1 selects parallel control, 0 selects serial |
| ser_data | input | 1 | Serial data bit |
| ser_clk | input | 1 | Serial shift clock, sampled by `clk` |
| ser_le | input | 1 | Serial latch enable; latch transparent while high |
| par_code | input | 6 | Parallel attenuation code |
| pup_sel | input | 2 | Power-up code selection |
| att_code | output | 6 | Registered attenuation code, bit 5 = 16 dB |

## Verification
The bench checks the output after every shifted bit with latch-enable low. A latch that was transparent at the wrong level would show partial words there. It shifts words longer than six bits, so a register that kept the wrong end of the stream, or shifted LSB first, would latch a different code. It also holds latch-enable high while shifting, to catch a latch built as an edge-loaded register. Further checks cover each power-up selection, the hold of the power-up code when reset releases, the pulse right after reset that must give zero, and cross-mode stimulus that must leave the output alone.

// File: rtl/step_atten_ctrl.sv
module step_atten_ctrl #(
  parameter int W   = 6,
  parameter int MID = 1 << (W - 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         par_mode,
  input  logic         ser_data,
  input  logic         ser_clk,
  input  logic         ser_le,
  input  logic [W-1:0] par_code,
  input  logic [1:0]   pup_sel,
  output logic [W-1:0] att_code
);

  localparam logic [W-1:0] MAX_CODE = '1;
  localparam logic [W-1:0] MID_CODE = W'(MID);

  logic         sclk_s, sclk_d, sdat_s, sle_s;
  logic [W-1:0] sreg, par_prev, pup_code;

  wire shift_en = sclk_s & ~sclk_d;
  wire par_evt  = par_mode & (par_code != par_prev);

  always_comb begin
    case (pup_sel)
      2'b00:   pup_code = '0;
      2'b01:   pup_code = MAX_CODE;
      2'b10:   pup_code = MID_CODE;
      default: pup_code = par_code;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_s <= 1'b0;
      sclk_d <= 1'b0;
      sdat_s <= 1'b0;
      sle_s  <= 1'b0;
    end else begin
      sclk_s <= ser_clk;
      sclk_d <= sclk_s;
      sdat_s <= ser_data;
      sle_s  <= ser_le;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           sreg <= '0;
    else if (shift_en) sreg <= {sreg[W-2:0], sdat_s};
  end

  always_ff @(posedge clk) par_prev <= par_code;

  always_ff @(posedge clk) begin
    if (rst)                       att_code <= pup_code;
    else if (par_evt)              att_code <= par_code;
    else if (!par_mode && sle_s)   att_code <= sreg;
  end

  AST_RST_ZERO: assert property (@(posedge clk) rst && pup_sel == 2'b00 |=> att_code == '0); // R1
  AST_RST_MAX:  assert property (@(posedge clk) rst && pup_sel == 2'b01 |=> att_code == MAX_CODE); // R1
  AST_RST_MID:  assert property (@(posedge clk) rst && pup_sel == 2'b10 |=> att_code == MID_CODE); // R1
  AST_RST_PAR:  assert property (@(posedge clk) rst && pup_sel == 2'b11 |=> att_code == $past(par_code)); // R1
  AST_HOLD_LE_LOW: assert property (@(posedge clk) disable iff (rst)
    !par_mode && !sle_s |=> $stable(att_code)); // R3
  AST_LE_TRANSPARENT: assert property (@(posedge clk) disable iff (rst)
    !par_mode && sle_s |=> att_code == $past(sreg)); // R4
  AST_PAR_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    par_mode && !$stable(par_code) |=> att_code == $past(par_code)); // R5
  AST_PAR_QUIET: assert property (@(posedge clk) disable iff (rst)
    par_mode && $stable(par_code) |=> $stable(att_code)); // R8

endmodule

// File: tb/step_atten_ctrl_tb_top.sv
`timescale 1ns/100ps
module step_atten_ctrl_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       par_mode = 1'b0;
  logic       ser_data = 1'b0;
  logic       ser_clk = 1'b0;
  logic       ser_le = 1'b0;
  logic [5:0] par_code = '0;
  logic [1:0] pup_sel = '0;
  logic [5:0] att_code;

  int vectors = 0;
  int errors  = 0;
  logic [5:0] m_sreg = '0, m_att = '0, m_par = '0;

  always #2.5 clk = ~clk;

  step_atten_ctrl dut_i (
    .clk(clk), .rst(rst), .par_mode(par_mode), .ser_data(ser_data),
    .ser_clk(ser_clk), .ser_le(ser_le), .par_code(par_code),
    .pup_sel(pup_sel), .att_code(att_code)
  );

  function automatic logic [5:0] exp_pup(input logic [1:0] sel, input logic [5:0] par);
    case (sel)
      2'b00:   return 6'd0;
      2'b01:   return 6'd63;
      2'b10:   return 6'd32;
      default: return par;
    endcase
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [5:0] exp);
    vectors++;
    if (att_code !== exp) begin
      errors++;
      $display("FAIL %s: att_code=%0d expected %0d at %0t", req, att_code, exp, $time);
    end
  endtask

  task automatic do_reset(input logic [1:0] sel, input logic [5:0] par, input logic mode);
    rst = 1'b1; pup_sel = sel; par_code = par; par_mode = mode;
    ser_clk = 1'b0; ser_le = 1'b0;
    tick(2);
    rst = 1'b0;
    m_sreg = '0; m_par = par; m_att = exp_pup(sel, par);
    tick(1);
    chk("R1", m_att);
  endtask

  task automatic shift_bit(input logic b);
    ser_data = b; ser_clk = 1'b1;
    tick(2);
    ser_clk = 1'b0;
    tick(2);
    m_sreg = {m_sreg[4:0], b};
    if (!par_mode && ser_le) m_att = m_sreg;
  endtask

  task automatic shift_word(input logic [5:0] w, input int extra);
    for (int i = extra - 1; i >= 0; i--) begin
      shift_bit(1'b1);
      chk("R3", m_att);
    end
    for (int i = 5; i >= 0; i--) begin
      shift_bit(w[i]);
      chk("R3", m_att);
    end
  endtask

  task automatic pulse_le();
    ser_le = 1'b1;
    tick(3);
    ser_le = 1'b0;
    tick(3);
    if (!par_mode) m_att = m_sreg;
  endtask

  task automatic set_par(input logic [5:0] v);
    par_code = v;
    tick(2);
    if (par_mode && v != m_par) m_att = v;
    m_par = v;
  endtask

  task automatic set_mode(input logic m);
    par_mode = m;
    tick(2);
  endtask

  initial begin
    void'($urandom(32'd7321));
    tick(3);
    // R1 each power-up selection, R6 hold after release
    for (int s = 0; s < 4; s++) begin
      do_reset(2'(s), 6'd21 + 6'(s), 1'b0);
      shift_word(6'd9, 0);
      chk("R6", m_att);
    end
    // R10 shift register cleared by reset
    do_reset(2'b01, 6'd5, 1'b0);
    pulse_le();
    chk("R10", 6'd0);
    // R2 R4 R7: MSB first, 45 = 16+4+2+0.5 dB encoding
    shift_word(6'b101101, 0);
    pulse_le();
    chk("R2", 6'd45);
    shift_word(6'b010011, 3);
    pulse_le();
    chk("R2", 6'd19);
    // R4 transparent while LE held high
    ser_le = 1'b1;
    tick(3);
    for (int i = 0; i < 6; i++) begin
      shift_bit(1'(i % 2));
      chk("R4", m_sreg);
    end
    ser_le = 1'b0;
    tick(2);
    // R9 parallel lines ignored in serial mode
    set_par(6'd60);
    chk("R9", m_att);
    // R6 parallel mode holds power-up code until a change
    do_reset(2'b10, 6'd7, 1'b1);
    tick(4);
    chk("R6", 6'd32);
    set_par(6'd7);
    chk("R6", 6'd32);
    set_par(6'd12);
    chk("R5", 6'd12);
    // R8 LE ignored in parallel mode
    shift_word(6'd50, 0);
    pulse_le();
    chk("R8", 6'd12);
    // R1 with code taken from parallel lines
    do_reset(2'b11, 6'd44, 1'b1);
    set_par(6'd0);
    chk("R5", 6'd0);

    for (int it = 0; it < 400; it++) begin
      case ($urandom % 6)
        0: begin shift_word(6'($urandom), int'($urandom % 3)); end
        1: begin pulse_le(); chk(par_mode ? "R8" : "R4", m_att); end
        2: begin set_par(6'($urandom)); chk(par_mode ? "R5" : "R9", m_att); end
        3: begin set_mode(1'($urandom)); chk("R6", m_att); end
        4: begin shift_bit(1'($urandom)); chk("R3", m_att); end
        default: begin
          if ($urandom % 8 == 0) do_reset(2'($urandom), 6'($urandom), 1'($urandom));
          else begin set_par(m_par); chk("R5", m_att); end
        end
      endcase
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #750000;
    errors++;
    $display("FAIL watchdog: att_code=%0d expected completion", att_code);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule